// File: doc/BRIEF.md
# Shared Local RAM Access Controller for a Serial Slave

This block connects the byte-level transaction front end of a serial slave (SPI or I2C) to a 256-byte local RAM that a local CPU also uses. Three base fields, each a byte offset shifted right by 3, divide the RAM at run time into four regions:

- **Direct:** from 0 up to the read-only base. Both sides may read and write it.
- **Host read-only:** from the read-only base up to the FIFO base. The host may only read it.
- **FIFO:** from the FIFO base up to the private base. The CPU fills it and the host drains it.
- **CPU-private:** at and above the private base. The host cannot reach it.

Each host transaction is checked against these rules. A host read of the pop address 0x7F takes the next FIFO byte instead of reading RAM.

The CPU side has a plain read/write port to every byte and a push strobe that appends one byte to the FIFO. The block drives these outputs:

- a level interrupt while the FIFO count is below a threshold;
- sticky flags for overflow, underflow and direct host reads of the FIFO region;
- a 32-bit access-flag word that records host accesses to selected addresses.

An option reverses the bit order of host write data for LSB-first links.

A host request runs through a seven-state machine:

- **IDLE:** waits for a request. On `h_req` it latches the request and goes to CHECK.
- **CHECK:** decides what to do and goes to one of WRITE, READ, POP or DENY.
- **WRITE:** stores the byte to RAM.
- **READ:** fetches the byte from RAM.
- **POP:** reads the byte at the FIFO read pointer and advances the pointer.
- **DENY:** refuses the request.
- **DONE:** WRITE, READ, POP and DENY all go to DONE. DONE raises the acknowledge for one cycle and returns to IDLE.

Top module: `hsram_ctrl`

## Requirements
- R1: The configuration is in error, with `cfg_err` high, when any of these holds: the read-only base field is greater than the FIFO base field, the FIFO base field is greater than the private base field, or the private base field is greater than 32. While `cfg_err` is high, every host request is refused (`h_err`=1, `h_rdata`=0), no RAM byte is written, and no pop happens.
- R2: A request is sampled only in IDLE. `h_ack` is high for exactly one cycle, three clock edges after the edge that sampled `h_req`. `h_err` and `h_rdata` are valid while `h_ack` is high.
- R3: Host reads and writes of addresses below the read-only base byte offset succeed with `h_err`=0. A read returns the stored byte.
- R4: Host writes to the read-only region are refused with `h_err`=1 and leave the RAM unchanged. Host reads there succeed. The CPU may write it.
- R5: Direct host accesses to the FIFO region, other than a read of 0x7F, are refused. Such a read also sets `irq_flags[2]` (read error).
- R6: Host accesses at or above the private base byte offset are refused. CPU accesses there work normally.
- R7: In any region, a host read of 0x7F returns FIFO bytes in push order and decrements the count. On an empty FIFO the read is refused with `h_rdata`=0 and sets `irq_flags[1]` (underflow).
- R8: The FIFO holds up to (private base − FIFO base) bytes. A push while full is dropped and sets `irq_flags[0]` (overflow). The read and write pointers wrap to the FIFO base at the end of the region.
- R9: `irq_fsize` is high whenever the configuration is valid and the FIFO count is less than `cfg_fifo_thresh`.
- R10: A `fifo_clr` pulse, or any change of the FIFO bounds, empties the FIFO and returns both pointers to the FIFO base.
- R11: A granted host read or write sets one bit of `acc_flags` for its address. Address a in 0x00–0x0F sets bit 31−a. Address 0x13+4k, for k = 0 to 15, sets bit 15−k. Bits stay set until `acc_clr` clears them; a set in the same cycle wins over the clear.
- R12: While `cfg_lsb_first`=1, the host write byte is stored bit-reversed.
- R13: `irq_flags` bits are sticky and cleared by the matching `irq_clr` bit.
- R14: The CPU port reads any address with one cycle of latency and writes any address. A push in the same cycle as a CPU write takes the port, and the CPU write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ro_base | input | 4 | Read-only region base, byte offset >> 3 |
| cfg_fifo_base | input | 4 | FIFO region base, byte offset >> 3 |
| cfg_ram_base | input | 6 | CPU-private region base, byte offset >> 3 |
| cfg_lsb_first | input | 1 | Reverse the bit order of host write data |
| cfg_fifo_thresh | input | 9 | FIFO count threshold for `irq_fsize` |
| h_req | input | 1 | Host request strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 8 | Host byte address |
| h_wdata | input | 8 | Host write byte |
| h_ack | output | 1 | Host transaction complete |
| h_err | output | 1 | Host transaction refused |
| h_rdata | output | 8 | Host read byte |
| c_req | input | 1 | CPU access strobe |
| c_we | input | 1 | CPU write (1) or read (0) |
| c_addr | input | 8 | CPU byte address |
| c_wdata | input | 8 | CPU write byte |
| c_rdata | output | 8 | CPU read byte, one cycle after the request |
| c_push | input | 1 | CPU FIFO push strobe |
| c_pdata | input | 8 | CPU FIFO push byte |
| fifo_clr | input | 1 | Empty the FIFO |
| irq_fsize | output | 1 | FIFO count below threshold |
| irq_flags | output | 3 | Sticky flags: [0] overflow, [1] underflow, [2] read error |
| irq_clr | input | 3 | Clear mask for `irq_flags` |
| acc_flags | output | 32 | Sticky per-address host access flags |
| acc_clr | input | 32 | Clear mask for `acc_flags` |
| cfg_err | output | 1 | Invalid ordering of the region bases |

## Verification
The assertions check on every cycle the properties that do not depend on data values:

- the acknowledge latency and its one-cycle width;
- no host RAM write outside the direct region or under a configuration error;
- no pop from an empty FIFO;
- a count that never exceeds the FIFO size and does not move when a push is dropped while full.

Only the directed scenarios can show that the data is right:

- FIFO bytes come back in push order across a pointer wrap;
- refused writes leave the RAM unchanged;
- the access-flag bit positions are correct;
- bit reversal is applied;
- the CPU write loses to a push in the same cycle.

// File: rtl/hsram_pkg.sv
package hsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WRITE,
        ST_READ,
        ST_POP,
        ST_DENY,
        ST_DONE
    } host_st_e;

    localparam int unsigned FLAG_OVF   = 0;
    localparam int unsigned FLAG_UDF   = 1;
    localparam int unsigned FLAG_RDERR = 2;
    localparam int unsigned FLAG_N     = 3;

    function automatic logic [7:0] rev_byte(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

endpackage

// File: rtl/hsram_lram.sv
module hsram_lram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [DW-1:0] a_wd,
    output logic [DW-1:0] a_rd,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [DW-1:0] b_wd,
    output logic [DW-1:0] b_rd
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wd;
        if (b_we) mem[b_addr] <= b_wd;
        a_rd <= mem[a_addr];
        b_rd <= mem[b_addr];
    end
endmodule

// File: rtl/hsram_fifo_ptr.sv
module hsram_fifo_ptr #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW:0]   lo,
    input  logic [AW:0]   size,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   cnt,
    output logic          full,
    output logic          empty
);
    logic [AW-1:0] wr_off, rd_off;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] off, input logic [AW:0] sz);
        return ({1'b0, off} + 1'b1 == sz) ? '0 : off + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_off <= '0;
            rd_off <= '0;
            cnt    <= '0;
        end else if (clr) begin
            wr_off <= '0;
            rd_off <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_off <= step(wr_off, size);
            if (pop)  rd_off <= step(rd_off, size);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign wr_addr = AW'(lo + {1'b0, wr_off});
    assign rd_addr = AW'(lo + {1'b0, rd_off});
    assign full    = (cnt == size);
    assign empty   = (cnt == '0);
endmodule

// File: rtl/hsram_acc_map.sv
module hsram_acc_map #(
    parameter int unsigned AW       = 8,
    parameter int unsigned FLAG_W   = 32,
    parameter int unsigned LOW_N    = 16,
    parameter int unsigned STEP_ORG = 'h13,
    parameter int unsigned STEP     = 4
) (
    input  logic [AW-1:0]     addr,
    output logic [FLAG_W-1:0] hit
);
    localparam int unsigned STEP_N = FLAG_W - LOW_N;

    for (genvar i = 0; i < LOW_N; i++) begin : g_low
        assign hit[FLAG_W-1-i] = (addr == AW'(i));
    end
    for (genvar k = 0; k < STEP_N; k++) begin : g_step
        assign hit[STEP_N-1-k] = (addr == AW'(STEP_ORG + STEP * k));
    end
endmodule

// File: rtl/hsram_ctrl.sv
module hsram_ctrl
    import hsram_pkg::*;
#(
    parameter int unsigned AW       = 8,
    parameter int unsigned GSH      = 3,
    parameter int unsigned POP_ADDR = 'h7F,
    parameter int unsigned FLAG_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-GSH-2:0]   cfg_ro_base,
    input  logic [AW-GSH-2:0]   cfg_fifo_base,
    input  logic [AW-GSH:0]     cfg_ram_base,
    input  logic                cfg_lsb_first,
    input  logic [AW:0]         cfg_fifo_thresh,
    input  logic                h_req,
    input  logic                h_we,
    input  logic [AW-1:0]       h_addr,
    input  logic [7:0]          h_wdata,
    output logic                h_ack,
    output logic                h_err,
    output logic [7:0]          h_rdata,
    input  logic                c_req,
    input  logic                c_we,
    input  logic [AW-1:0]       c_addr,
    input  logic [7:0]          c_wdata,
    output logic [7:0]          c_rdata,
    input  logic                c_push,
    input  logic [7:0]          c_pdata,
    input  logic                fifo_clr,
    output logic                irq_fsize,
    output logic [FLAG_N-1:0]   irq_flags,
    input  logic [FLAG_N-1:0]   irq_clr,
    output logic [FLAG_W-1:0]   acc_flags,
    input  logic [FLAG_W-1:0]   acc_clr,
    output logic                cfg_err
);
    localparam int unsigned BW      = AW + 1;
    localparam int unsigned RB_W    = AW - GSH + 1;
    localparam int unsigned RAM_MAX = 1 << (AW - GSH);

    host_st_e state, nxt;

    logic [AW-1:0] lat_addr;
    logic          lat_we;
    logic [7:0]    lat_wd;
    logic          err_q, rd_q;

    logic [BW-1:0] ro_byte, fifo_byte, ram_byte, fifo_size;
    logic [BW-1:0] lo_q, sz_q;
    logic          bound_chg, clr_eff;

    logic [AW-1:0] fifo_wr_addr, fifo_rd_addr;
    logic [BW-1:0] fifo_cnt;
    logic          fifo_full, fifo_empty, fifo_pop, push_ok;

    logic          in_direct, in_fifo, in_vis, is_pop;
    logic          host_we;
    logic [AW-1:0] host_addr;
    logic [7:0]    ram_hq;
    logic          cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [7:0]    cpu_wd;
    logic          set_udf, set_rderr, set_ovf;
    logic [FLAG_W-1:0] acc_hit, acc_set;

    // region bounds and configuration check
    assign ro_byte   = BW'(cfg_ro_base)   << GSH;
    assign fifo_byte = BW'(cfg_fifo_base) << GSH;
    assign ram_byte  = BW'(cfg_ram_base)  << GSH;
    assign fifo_size = ram_byte - fifo_byte;
    assign cfg_err   = (cfg_ro_base > cfg_fifo_base)
                     | (RB_W'(cfg_fifo_base) > cfg_ram_base)
                     | (cfg_ram_base > RB_W'(RAM_MAX));

    assign bound_chg = (lo_q != fifo_byte) | (sz_q != fifo_size);
    assign clr_eff   = fifo_clr | bound_chg;

    // host address decode on the latched request
    assign in_direct = {1'b0, lat_addr} < ro_byte;
    assign in_vis    = {1'b0, lat_addr} < ram_byte;
    assign in_fifo   = in_vis && ({1'b0, lat_addr} >= fifo_byte);
    assign is_pop    = !lat_we && (lat_addr == AW'(POP_ADDR));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (h_req) nxt = ST_CHECK;
            ST_CHECK: begin
                if (cfg_err)     nxt = ST_DENY;
                else if (is_pop) nxt = fifo_empty ? ST_DENY : ST_POP;
                else if (lat_we) nxt = in_direct ? ST_WRITE : ST_DENY;
                else             nxt = (in_vis && !in_fifo) ? ST_READ : ST_DENY;
            end
            ST_WRITE, ST_READ, ST_POP, ST_DENY: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        h_ack     = (state == ST_DONE);
        h_err     = h_ack && err_q;
        h_rdata   = (h_ack && rd_q && !err_q) ? ram_hq : 8'h00;
        host_we   = (state == ST_WRITE);
        fifo_pop  = (state == ST_POP);
        host_addr = fifo_pop ? fifo_rd_addr : lat_addr;
        set_udf   = (state == ST_CHECK) && !cfg_err && is_pop && fifo_empty;
        set_rderr = (state == ST_CHECK) && !cfg_err && !lat_we && !is_pop && in_fifo;
        acc_set   = (state == ST_WRITE || state == ST_READ) ? acc_hit : '0;
    end

    // request latch, response qualifiers, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_we    <= 1'b0;
            lat_wd    <= '0;
            err_q     <= 1'b0;
            rd_q      <= 1'b0;
            lo_q      <= '0;
            sz_q      <= '0;
            irq_flags <= '0;
            acc_flags <= '0;
        end else begin
            if (state == ST_IDLE && h_req) begin
                lat_addr <= h_addr;
                lat_we   <= h_we;
                lat_wd   <= cfg_lsb_first ? rev_byte(h_wdata) : h_wdata;
            end
            if (state == ST_CHECK) begin
                err_q <= (nxt == ST_DENY);
                rd_q  <= !lat_we;
            end
            lo_q      <= fifo_byte;
            sz_q      <= fifo_size;
            irq_flags <= (irq_flags & ~irq_clr) | {set_rderr, set_udf, set_ovf};
            acc_flags <= (acc_flags & ~acc_clr) | acc_set;
        end
    end

    // CPU side: push takes the port over a plain write
    assign push_ok  = c_push && !fifo_full && !cfg_err;
    assign set_ovf  = c_push && fifo_full && !cfg_err;
    assign cpu_we   = push_ok || (c_req && c_we && !c_push);
    assign cpu_addr = c_push ? fifo_wr_addr : c_addr;
    assign cpu_wd   = c_push ? c_pdata : c_wdata;

    assign irq_fsize = !cfg_err && (fifo_cnt < cfg_fifo_thresh);

    hsram_lram #(.AW(AW), .DW(8)) u_ram (
        .clk    (clk),
        .a_addr (cpu_addr),
        .a_we   (cpu_we),
        .a_wd   (cpu_wd),
        .a_rd   (c_rdata),
        .b_addr (host_addr),
        .b_we   (host_we),
        .b_wd   (lat_wd),
        .b_rd   (ram_hq)
    );

    hsram_fifo_ptr #(.AW(AW)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_eff),
        .lo      (fifo_byte),
        .size    (fifo_size),
        .push    (push_ok),
        .pop     (fifo_pop),
        .wr_addr (fifo_wr_addr),
        .rd_addr (fifo_rd_addr),
        .cnt     (fifo_cnt),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    hsram_acc_map #(.AW(AW), .FLAG_W(FLAG_W)) u_acc (
        .addr (lat_addr),
        .hit  (acc_hit)
    );
endmodule

// File: rtl/hsram_ctrl_chk.sv
module hsram_ctrl_chk
    import hsram_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input host_st_e      state,
    input logic          h_req,
    input logic          h_ack,
    input logic          host_we,
    input logic [AW-1:0] host_addr,
    input logic [AW:0]   ro_byte,
    input logic          cfg_err,
    input logic [AW:0]   fifo_cnt,
    input logic [AW:0]   fifo_size,
    input logic          fifo_full,
    input logic          fifo_pop,
    input logic          c_push,
    input logic          clr_eff,
    input logic          bound_chg
);
    AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && h_req) |-> ##3 h_ack); // R2
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        h_ack |=> !h_ack); // R2
    AST_CFG_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |-> !$past(cfg_err)); // R1
    AST_NO_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |-> ({1'b0, host_addr} < $past(ro_byte))); // R4
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_cnt != '0)); // R7
    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_err && !bound_chg) |-> (fifo_cnt <= fifo_size)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (c_push && fifo_full && !fifo_pop && !clr_eff) |=> $stable(fifo_cnt)); // R8
endmodule

bind hsram_ctrl hsram_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .h_req     (h_req),
    .h_ack     (h_ack),
    .host_we   (host_we),
    .host_addr (host_addr),
    .ro_byte   (ro_byte),
    .cfg_err   (cfg_err),
    .fifo_cnt  (fifo_cnt),
    .fifo_size (fifo_size),
    .fifo_full (fifo_full),
    .fifo_pop  (fifo_pop),
    .c_push    (c_push),
    .clr_eff   (clr_eff),
    .bound_chg (bound_chg)
);

// File: tb/hsram_ctrl_tb.sv
`timescale 1ns/1ps
module hsram_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_ro_base = 4'd4, cfg_fifo_base = 4'd8;
    logic [5:0]  cfg_ram_base = 6'd16;
    logic        cfg_lsb_first = 1'b0;
    logic [8:0]  cfg_fifo_thresh = 9'd4;
    logic        h_req = 0, h_we = 0;
    logic [7:0]  h_addr = 0, h_wdata = 0;
    logic        h_ack, h_err;
    logic [7:0]  h_rdata;
    logic        c_req = 0, c_we = 0, c_push = 0, fifo_clr = 0;
    logic [7:0]  c_addr = 0, c_wdata = 0, c_pdata = 0, c_rdata;
    logic        irq_fsize, cfg_err;
    logic [2:0]  irq_flags, irq_clr = 0;
    logic [31:0] acc_flags, acc_clr = 0;

    int n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;

    hsram_ctrl u_dut (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_xfer(input logic we, input logic [7:0] a, input logic [7:0] d,
                             output logic [7:0] rd, output logic err, output int lat);
        @(negedge clk);
        h_req = 1; h_we = we; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_req = 0;
        lat = 1;
        while (!h_ack && lat < 20) begin @(negedge clk); lat++; end
        rd = h_rdata; err = h_err;
    endtask

    task automatic cpu_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); c_req = 1; c_we = 1; c_addr = a; c_wdata = d;
        @(negedge clk); c_req = 0; c_we = 0;
    endtask

    task automatic cpu_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); c_req = 1; c_we = 0; c_addr = a;
        @(negedge clk); d = c_rdata; c_req = 0;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); c_push = 1; c_pdata = d;
        @(negedge clk); c_push = 0;
    endtask

    task automatic clear_all();
        @(negedge clk); irq_clr = '1; acc_clr = '1; fifo_clr = 1;
        @(negedge clk); irq_clr = '0; acc_clr = '0; fifo_clr = 0;
    endtask

    task automatic set_cfg(input logic [3:0] ro, input logic [3:0] ff, input logic [5:0] rm);
        @(negedge clk); cfg_ro_base = ro; cfg_fifo_base = ff; cfg_ram_base = rm;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R2 reset ack", h_ack, 0);
        chk("R13 reset flags", irq_flags, 0);
        chk("R11 reset acc", acc_flags, 0);
        chk("R1 valid cfg", cfg_err, 0);
        chk("R9 fsize empty", irq_fsize, 1);
    endtask

    task automatic t_direct();
        logic [7:0] rd; logic e; int lat;
        host_xfer(1, 8'h05, 8'hA5, rd, e, lat);
        chk("R2 latency", lat, 3);
        chk("R3 write err", e, 0);
        cpu_rd(8'h05, rd);
        chk("R3 stored", rd, 8'hA5);
        host_xfer(0, 8'h05, 0, rd, e, lat);
        chk("R3 host read", rd, 8'hA5);
        @(negedge clk);
        chk("R2 ack pulse", h_ack, 0);
        host_xfer(0, 8'h13, 0, rd, e, lat);
        host_xfer(0, 8'h23, 0, rd, e, lat);
        chk("R11 acc bits", acc_flags, 32'h0400_8800);
        @(negedge clk); acc_clr = 32'h0400_0000;
        @(negedge clk); acc_clr = '0;
        chk("R11 partial clear", acc_flags, 32'h0000_8800);
        clear_all();
    endtask

    task automatic t_ro();
        logic [7:0] rd; logic e; int lat;
        cpu_wr(8'h22, 8'h3C);
        host_xfer(1, 8'h22, 8'hFF, rd, e, lat);
        chk("R4 write refused", e, 1);
        cpu_rd(8'h22, rd);
        chk("R4 ram unchanged", rd, 8'h3C);
        host_xfer(0, 8'h22, 0, rd, e, lat);
        chk("R4 host read", rd, 8'h3C);
        chk("R11 refused write no flag", acc_flags, 32'h0);
    endtask

    task automatic t_fifo_region();
        logic [7:0] rd; logic e; int lat;
        host_xfer(0, 8'h45, 0, rd, e, lat);
        chk("R5 read refused", e, 1);
        chk("R5 rderr flag", irq_flags, 3'b100);
        @(negedge clk); irq_clr = 3'b100;
        @(negedge clk); irq_clr = 0;
        chk("R13 flag cleared", irq_flags, 0);
        host_xfer(1, 8'h45, 8'h1, rd, e, lat);
        chk("R5 write refused", e, 1);
    endtask

    task automatic t_private();
        logic [7:0] rd; logic e; int lat;
        cpu_wr(8'h90, 8'h11);
        host_xfer(1, 8'h90, 8'h22, rd, e, lat);
        chk("R6 write refused", e, 1);
        host_xfer(0, 8'h90, 0, rd, e, lat);
        chk("R6 read refused", e, 1);
        chk("R6 read data zero", rd, 0);
        cpu_rd(8'h90, rd);
        chk("R6 cpu sees value", rd, 8'h11);
    endtask

    task automatic t_fifo();
        logic [7:0] rd; logic e; int lat;
        clear_all();
        for (int i = 1; i <= 3; i++) push(8'(i));
        @(negedge clk);
        chk("R9 below thresh", irq_fsize, 1);
        push(8'd4);
        @(negedge clk);
        chk("R9 at thresh", irq_fsize, 0);
        for (int i = 1; i <= 4; i++) begin
            host_xfer(0, 8'h7F, 0, rd, e, lat);
            chk("R7 pop order", rd, i);
        end
        host_xfer(0, 8'h7F, 0, rd, e, lat);
        chk("R7 empty refused", e, 1);
        chk("R7 empty data", rd, 0);
        chk("R7 udf flag", irq_flags, 3'b010);
        clear_all();
    endtask

    task automatic t_wrap();
        logic [7:0] rd; logic e; int lat;
        set_cfg(4'd4, 4'd8, 6'd9);
        clear_all();
        for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
        push(8'hEE);
        @(negedge clk);
        chk("R8 ovf flag", irq_flags, 3'b001);
        for (int i = 0; i < 3; i++) begin
            host_xfer(0, 8'h7F, 0, rd, e, lat);
            chk("R8 pop before wrap", rd, 8'h10 + i);
        end
        for (int i = 0; i < 3; i++) push(8'h20 + 8'(i));
        cpu_rd(8'h40, rd);
        chk("R8 wrap location", rd, 8'h20);
        for (int i = 0; i < 8; i++) begin
            host_xfer(0, 8'h7F, 0, rd, e, lat);
            chk("R8 pop after wrap", rd, (i < 5) ? 8'h13 + i : 8'h20 + i - 5);
        end
        host_xfer(0, 8'h7F, 0, rd, e, lat);
        chk("R8 drained", e, 1);
        set_cfg(4'd4, 4'd8, 6'd16);
        clear_all();
    endtask

    task automatic t_clr();
        logic [7:0] rd; logic e; int lat;
        push(8'h61); push(8'h62);
        @(negedge clk); fifo_clr = 1;
        @(negedge clk); fifo_clr = 0;
        host_xfer(0, 8'h7F, 0, rd, e, lat);
        chk("R10 cleared fifo empty", e, 1);
        push(8'h63); push(8'h64);
        set_cfg(4'd4, 4'd8, 6'd15);
        host_xfer(0, 8'h7F, 0, rd, e, lat);
        chk("R10 bound change empties", e, 1);
        set_cfg(4'd4, 4'd8, 6'd16);
        clear_all();
    endtask

    task automatic t_cfg_err();
        logic [7:0] rd; logic e; int lat;
        set_cfg(4'd9, 4'd8, 6'd16);
        chk("R1 ro above fifo", cfg_err, 1);
        host_xfer(1, 8'h05, 8'h77, rd, e, lat);
        chk("R1 write refused", e, 1);
        cpu_rd(8'h05, rd);
        chk("R1 ram unchanged", rd, 8'hA5);
        host_xfer(0, 8'h05, 0, rd, e, lat);
        chk("R1 read data zero", rd, 0);
        set_cfg(4'd4, 4'd8, 6'd33);
        chk("R1 ram base too big", cfg_err, 1);
        set_cfg(4'd4, 4'd8, 6'd16);
        chk("R1 restored", cfg_err, 0);
        clear_all();
    endtask

    task automatic t_lsb();
        logic [7:0] rd; logic e; int lat;
        cfg_lsb_first = 1;
        host_xfer(1, 8'h06, 8'h01, rd, e, lat);
        cpu_rd(8'h06, rd);
        chk("R12 reversed", rd, 8'h80);
        cfg_lsb_first = 0;
        clear_all();
    endtask

    task automatic t_cpu_prio();
        logic [7:0] rd; logic e; int lat;
        cpu_wr(8'h07, 8'h33);
        @(negedge clk);
        c_push = 1; c_pdata = 8'h5A; c_req = 1; c_we = 1; c_addr = 8'h07; c_wdata = 8'h55;
        @(negedge clk);
        c_push = 0; c_req = 0; c_we = 0;
        cpu_rd(8'h07, rd);
        chk("R14 cpu write dropped", rd, 8'h33);
        host_xfer(0, 8'h7F, 0, rd, e, lat);
        chk("R14 push kept", rd, 8'h5A);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk); @(negedge clk);
        t_reset();
        t_direct();
        t_ro();
        t_fifo_region();
        t_private();
        t_fifo();
        t_wrap();
        t_clr();
        t_cfg_err();
        t_lsb();
        t_cpu_prio();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule